// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block walks a ring of transmit descriptors kept in memory for a bus-mastering network controller. Each ring entry is two words. The first word holds the buffer address. The second word holds the flag bits (ownership, start of packet, end of packet) and the byte count. On a poll, the walker reads the current entry through a simple single-port memory interface and acts on what it finds. If the entry is not owned, it goes back to waiting. If the entry is an orphaned middle-of-chain entry or a zero-length entry, it releases the entry by writing the second word back with ownership cleared and moves straight on. If the entry holds data, it hands the buffer to the data mover.

While the first buffer of a chained packet is being moved, the walker reads ahead one entry. It keeps that entry's address word and flag/count word so the data mover can see whether the chain goes on. This lookahead happens once per packet, and only after the data mover has reported progress on the first buffer. When the data mover signals that a buffer is finished, the walker advances its index and reads the next entry without waiting for a poll. The index wraps at a power-of-two ring length that software selects.

Top module: `tx_ring_walker`

## Requirements
- R1: When the entry read has its ownership bit clear, the walker returns to idle without writing memory, keeps its index, and reads the same entry again on the next poll.
- R2: An owned entry with start-of-packet clear, read while no chained packet is open, is released: its second word is written back with only the ownership bit cleared. The next entry is then read without a poll.
- R3: An owned entry with a byte count of zero is released and never handed to the data mover, whatever its start-of-packet flag.
- R4: A released zero-length entry with start-of-packet clear and end-of-packet set raises `desc_err` for one cycle. A zero-length entry with start-of-packet set raises no error.
- R5: An owned entry with start-of-packet set and a nonzero count produces a one-cycle `xfer_start`. With it come the buffer address, the byte count and the end-of-packet flag. An owned entry with start-of-packet clear that follows the first buffer of an open chained packet is handed over the same way.
- R6: The lookahead read happens only for a packet whose first buffer has end-of-packet clear, and only after at least one `xfer_beat` for that buffer.
- R7: The lookahead reads the next entry's address word first and its flag/count word second. It presents both on `nxt_addr` and `nxt_word` with `nxt_valid` set, whether or not that entry is owned.
- R8: The lookahead is done at most once per packet. Further beats cause no extra reads, and the captured values stay stable.
- R9: On `xfer_done`, the index advances and the next entry is read at once. The index wraps from 2^`ring_lg2`-1 to 0.
- R10: Entry i sits at word addresses `ring_base`+2i (address) and `ring_base`+2i+1 (flags/count). In the flags/count word, bit 31 is ownership, bit 25 is start of packet, bit 24 is end of packet, and bits 11:0 are the byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll | input | 1 | Start a ring read when idle |
| ring_base | input | 16 | Word address of entry 0 |
| ring_lg2 | input | 4 | Log2 of the number of ring entries |
| xfer_beat | input | 1 | Data mover moved data from the current buffer |
| xfer_done | input | 1 | Data mover finished the current buffer |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read request |
| xfer_start | output | 1 | One-cycle pulse: buffer handed to data mover |
| xfer_addr | output | 32 | Buffer address of the handed-over entry |
| xfer_cnt | output | 12 | Byte count of the handed-over entry |
| xfer_last | output | 1 | End-of-packet flag of the handed-over entry |
| desc_err | output | 1 | One-cycle pulse: illegal zero-length entry |
| nxt_valid | output | 1 | Lookahead data captured |
| nxt_addr | output | 32 | Lookahead entry address word |
| nxt_word | output | 32 | Lookahead entry flags/count word |
| idle | output | 1 | Walker waiting for a poll |

## Verification
The bench goes after the ways a walker typically gets the ring wrong. If the design advanced past an unowned entry, a later poll would start the wrong buffer. If it treated a zero count as a large buffer, a start would appear for a released entry. If it flagged every zero-length entry, the error count would come out as two instead of one. A lookahead that ignored the first progress beat, or that repeated on later beats, would show up as extra read accesses or as a missing address/word capture of an unowned next entry. The last scenario continues a chain across the top of the ring and back to entry 0. A wrong wrap there would read past the ring.

// File: rtl/tx_ring_walker.sv
module tx_ring_walker #(
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int CW      = 12,
  parameter int LGW     = 4,
  parameter int OWN_BIT = 31,
  parameter int STP_BIT = 25,
  parameter int ENP_BIT = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          poll,
  input  logic [AW-1:0] ring_base,
  input  logic [LGW-1:0] ring_lg2,
  input  logic          xfer_beat,
  input  logic          xfer_done,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          xfer_start,
  output logic [DW-1:0] xfer_addr,
  output logic [CW-1:0] xfer_cnt,
  output logic          xfer_last,
  output logic          desc_err,
  output logic          nxt_valid,
  output logic [DW-1:0] nxt_addr,
  output logic [DW-1:0] nxt_word,
  output logic          idle
);
  localparam int IW = (1 << LGW) - 1;

  typedef enum logic [3:0] {
    S_IDLE, S_RD0, S_RD1, S_EV, S_WB, S_XF, S_LA0, S_LA1, S_LAC
  } st_t;

  st_t            st;
  logic [IW-1:0]  idx;
  logic [DW-1:0]  w0, w1;
  logic           in_pkt, la_pend, beat_seen, done_seen;

  logic [IW-1:0]  mask, nidx;
  logic [AW-1:0]  ent, la_ent;
  logic           own, stp, enp, zero;

  assign mask   = (IW'(1) << ring_lg2) - IW'(1);
  assign nidx   = (idx + IW'(1)) & mask;
  assign ent    = ring_base + AW'({idx, 1'b0});
  assign la_ent = ring_base + AW'({nidx, 1'b0});

  assign own  = mem_rdata[OWN_BIT];
  assign stp  = mem_rdata[STP_BIT];
  assign enp  = mem_rdata[ENP_BIT];
  assign zero = (mem_rdata[CW-1:0] == '0);

  assign idle      = (st == S_IDLE);
  assign mem_req   = (st == S_RD0) || (st == S_RD1) || (st == S_WB) ||
                     (st == S_LA0) || (st == S_LA1);
  assign mem_we    = (st == S_WB);
  assign mem_wdata = w1 & ~(DW'(1) << OWN_BIT);

  always_comb begin
    case (st)
      S_RD1, S_WB: mem_addr = ent + AW'(1);
      S_LA0:       mem_addr = la_ent;
      S_LA1:       mem_addr = la_ent + AW'(1);
      default:     mem_addr = ent;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      idx        <= '0;
      w0         <= '0;
      w1         <= '0;
      in_pkt     <= 1'b0;
      la_pend    <= 1'b0;
      beat_seen  <= 1'b0;
      done_seen  <= 1'b0;
      xfer_start <= 1'b0;
      xfer_addr  <= '0;
      xfer_cnt   <= '0;
      xfer_last  <= 1'b0;
      desc_err   <= 1'b0;
      nxt_valid  <= 1'b0;
      nxt_addr   <= '0;
      nxt_word   <= '0;
    end else begin
      xfer_start <= 1'b0;
      desc_err   <= 1'b0;
      if (st == S_XF || st == S_LA0 || st == S_LA1 || st == S_LAC) begin
        if (xfer_beat) beat_seen <= 1'b1;
        if (xfer_done) done_seen <= 1'b1;
      end
      case (st)
        S_IDLE: if (poll) st <= S_RD0;
        S_RD0:  st <= S_RD1;
        S_RD1: begin
          w0 <= mem_rdata;
          st <= S_EV;
        end
        S_EV: begin
          w1 <= mem_rdata;
          if (!own) begin
            st <= S_IDLE;
          end else if (zero) begin
            desc_err <= !stp && enp;
            in_pkt   <= enp ? 1'b0 : (stp ? 1'b1 : in_pkt);
            st       <= S_WB;
          end else if (!stp && !in_pkt) begin
            st <= S_WB;
          end else begin
            xfer_start <= 1'b1;
            xfer_addr  <= w0;
            xfer_cnt   <= mem_rdata[CW-1:0];
            xfer_last  <= enp;
            in_pkt     <= !enp;
            beat_seen  <= 1'b0;
            done_seen  <= 1'b0;
            if (stp) begin
              la_pend   <= !enp;
              nxt_valid <= 1'b0;
            end
            st <= S_XF;
          end
        end
        S_WB: begin
          idx <= nidx;
          st  <= S_RD0;
        end
        S_XF: begin
          if (la_pend && beat_seen) begin
            st <= S_LA0;
          end else if (done_seen || xfer_done) begin
            done_seen <= 1'b0;
            idx       <= nidx;
            st        <= S_RD0;
          end
        end
        S_LA0: st <= S_LA1;
        S_LA1: begin
          nxt_addr <= mem_rdata;
          st       <= S_LAC;
        end
        S_LAC: begin
          nxt_word  <= mem_rdata;
          nxt_valid <= 1'b1;
          la_pend   <= 1'b0;
          st        <= S_XF;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tx_ring_walker_chk.sv
module tx_ring_walker_chk #(
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int OWN_BIT = 31
) (
  input logic          clk,
  input logic          rst_n,
  input logic          idle,
  input logic          mem_req,
  input logic          mem_we,
  input logic [DW-1:0] mem_wdata,
  input logic          desc_err,
  input logic          xfer_start,
  input logic          nxt_valid,
  input logic [DW-1:0] nxt_addr
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !mem_req);

  p_release_own_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !mem_wdata[OWN_BIT]);

  p_err_releases_r4: assert property (@(posedge clk) disable iff (!rst_n)
    desc_err |-> (mem_req && mem_we));

  p_start_no_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> (!mem_req && !desc_err && !idle));

  p_la_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nxt_valid) |-> !idle);

  p_la_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nxt_valid |=> (!nxt_valid || $stable(nxt_addr)));
endmodule

bind tx_ring_walker tx_ring_walker_chk #(.AW(AW), .DW(DW), .OWN_BIT(OWN_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .idle(idle), .mem_req(mem_req), .mem_we(mem_we),
  .mem_wdata(mem_wdata), .desc_err(desc_err), .xfer_start(xfer_start),
  .nxt_valid(nxt_valid), .nxt_addr(nxt_addr)
);

// File: tb/sim_tx_ring_walker.sv
`timescale 1ns/1ps
module sim_tx_ring_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        poll = 1'b0;
  logic [15:0] ring_base = 16'h0010;
  logic [3:0]  ring_lg2 = 4'd3;
  logic        xfer_beat = 1'b0;
  logic        xfer_done = 1'b0;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        xfer_start, xfer_last, desc_err, nxt_valid, idle;
  logic [31:0] xfer_addr, nxt_addr, nxt_word;
  logic [11:0] xfer_cnt;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  tx_ring_walker u0 (
    .clk(clk), .rst_n(rst_n), .poll(poll), .ring_base(ring_base), .ring_lg2(ring_lg2),
    .xfer_beat(xfer_beat), .xfer_done(xfer_done), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .xfer_start(xfer_start), .xfer_addr(xfer_addr), .xfer_cnt(xfer_cnt),
    .xfer_last(xfer_last), .desc_err(desc_err), .nxt_valid(nxt_valid),
    .nxt_addr(nxt_addr), .nxt_word(nxt_word), .idle(idle)
  );

  logic [31:0] mem [64];
  logic        tb_we = 1'b0;
  logic [5:0]  tb_a = '0;
  logic [31:0] tb_d = '0;
  int n_rd = 0, n_wr = 0, n_err = 0, n_start = 0;
  logic [31:0] s_addr = '0;
  logic [11:0] s_cnt = '0;
  logic        s_last = 1'b0;
  logic [15:0] rd_last = '0, rd_prev = '0;

  initial for (int i = 0; i < 64; i++) mem[i] = '0;

  always @(posedge clk) begin
    if (tb_we) mem[tb_a] <= tb_d;
    if (mem_req && mem_we) begin
      mem[mem_addr[5:0]] <= mem_wdata;
      n_wr <= n_wr + 1;
    end else if (mem_req) begin
      mem_rdata <= mem[mem_addr[5:0]];
      n_rd <= n_rd + 1;
      rd_prev <= rd_last;
      rd_last <= mem_addr;
    end
    if (desc_err) n_err <= n_err + 1;
    if (xfer_start) begin
      n_start <= n_start + 1;
      s_addr <= xfer_addr;
      s_cnt <= xfer_cnt;
      s_last <= xfer_last;
    end
  end

  function automatic logic [31:0] fw(bit own, bit stp, bit enp, int cnt);
    return {own, 5'd0, stp, enp, 12'd0, cnt[11:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wcyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(int a, logic [31:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_a = 6'(a); tb_d = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic set_ent(int i, logic [31:0] a, logic [31:0] w);
    put(16 + 2*i, a);
    put(17 + 2*i, w);
  endtask

  task automatic pulse_poll;
    @(negedge clk); poll = 1'b1;
    @(negedge clk); poll = 1'b0;
  endtask

  task automatic pulse_beat;
    @(negedge clk); xfer_beat = 1'b1;
    @(negedge clk); xfer_beat = 1'b0;
  endtask

  task automatic pulse_done;
    @(negedge clk); xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 reset idle", 32'(idle), 1);
    chk("R1 reset no access", 32'(mem_req), 0);
    chk("R7 reset nxt_valid", 32'(nxt_valid), 0);
  endtask

  task automatic t_unowned;
    set_ent(0, 32'h1000, fw(0, 1, 1, 5));
    pulse_poll; wcyc(8);
    chk("R1 unowned idle", 32'(idle), 1);
    chk("R1 unowned no write", 32'(n_wr), 0);
    chk("R1 unowned reads", 32'(n_rd), 2);
    chk("R1 unowned no start", 32'(n_start), 0);
    set_ent(0, 32'h1000, fw(1, 1, 1, 5));
    pulse_poll; wcyc(8);
    chk("R1 same entry start", 32'(n_start), 1);
    chk("R5 start addr", s_addr, 32'h1000);
    chk("R10 start count", 32'(s_cnt), 5);
    chk("R5 start last", 32'(s_last), 1);
    pulse_done; wcyc(8);
    chk("R9 done reads next entry", 32'(n_rd), 6);
    chk("R9 unowned next idle", 32'(idle), 1);
  endtask

  task automatic t_orphan;
    set_ent(1, 32'h1100, fw(1, 0, 0, 4));
    set_ent(2, 32'h1200, fw(1, 1, 1, 7));
    pulse_poll; wcyc(12);
    chk("R2 writeback count", 32'(n_wr), 1);
    chk("R2 R10 own cleared", mem[8'h13], fw(0, 0, 0, 4));
    chk("R2 next without poll", 32'(n_start), 2);
    chk("R2 next buffer addr", s_addr, 32'h1200);
  endtask

  task automatic t_zero;
    set_ent(3, 32'h1300, fw(1, 1, 1, 0));
    set_ent(4, 32'h1400, fw(1, 0, 1, 0));
    pulse_done; wcyc(16);
    chk("R3 zero stp released", mem[8'h17], fw(0, 1, 1, 0));
    chk("R3 zero mid released", mem[8'h19], fw(0, 0, 1, 0));
    chk("R3 zero no start", 32'(n_start), 2);
    chk("R4 single error", 32'(n_err), 1);
    chk("R3 idle after", 32'(idle), 1);
  endtask

  task automatic t_lookahead;
    int r0;
    set_ent(5, 32'h1500, fw(1, 1, 1, 4));
    pulse_poll; wcyc(6);
    chk("R5 single start", s_addr, 32'h1500);
    r0 = n_rd;
    pulse_beat; pulse_beat; wcyc(6);
    chk("R6 no lookahead single", 32'(nxt_valid), 0);
    chk("R6 no lookahead reads", 32'(n_rd), 32'(r0));
    set_ent(6, 32'h1600, fw(1, 1, 0, 10));
    set_ent(7, 32'h1700, fw(0, 0, 1, 3));
    pulse_done; wcyc(8);
    chk("R5 chained start", s_addr, 32'h1600);
    chk("R5 chained last", 32'(s_last), 0);
    r0 = n_rd;
    wcyc(6);
    chk("R6 waits for beat", 32'(nxt_valid), 0);
    chk("R6 no read before beat", 32'(n_rd), 32'(r0));
    pulse_beat; wcyc(8);
    chk("R7 nxt_valid", 32'(nxt_valid), 1);
    chk("R7 nxt_addr", nxt_addr, 32'h1700);
    chk("R7 nxt_word unowned", nxt_word, fw(0, 0, 1, 3));
    chk("R7 order first", 32'(rd_prev), 32'h1E);
    chk("R7 order second", 32'(rd_last), 32'h1F);
    chk("R6 two lookahead reads", 32'(n_rd), 32'(r0 + 2));
    pulse_beat; pulse_beat; wcyc(8);
    chk("R8 once per packet", 32'(n_rd), 32'(r0 + 2));
    chk("R8 nxt stable", nxt_addr, 32'h1700);
    pulse_done; wcyc(8);
    chk("R1 continuation unowned idle", 32'(idle), 1);
    set_ent(7, 32'h1700, fw(1, 0, 1, 3));
    set_ent(0, 32'h1800, fw(1, 1, 1, 9));
    r0 = n_rd;
    pulse_poll; wcyc(8);
    chk("R5 continuation start", s_addr, 32'h1700);
    chk("R5 continuation last", 32'(s_last), 1);
    chk("R8 no second lookahead", 32'(n_rd), 32'(r0 + 2));
    pulse_done; wcyc(8);
    chk("R9 wrap to entry 0", s_addr, 32'h1800);
    chk("R9 wrap count", 32'(s_cnt), 9);
    pulse_done; wcyc(8);
    chk("R9 released entry idle", 32'(idle), 1);
  endtask

  initial begin
    wcyc(3);
    rst_n = 1'b1;
    wcyc(2);
    t_reset;
    t_unowned;
    t_orphan;
    t_zero;
    t_lookahead;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule